// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block is a small cache controller placed between a processor port and a slower main-memory port. Each line holds one word. The tag and the data of a line are kept together in one array that the block RAM of an FPGA can hold. The low-order bits of the word address pick the line. The remaining upper bits are the tag, so one equality comparator decides whether a lookup hits. A per-line valid bit, cleared by reset, must also be set for a hit.

The processor issues a request while `cpu_ready` is high. The controller then stalls the processor until the access completes, and it signals completion with a one-cycle `cpu_done`. A read hit is served from the array. A read miss fetches the word from memory, installs it and returns it. Every write goes to memory. A write also installs the written word in its line, whether that write hit or missed. The memory side uses a request/acknowledge handshake that tolerates any latency, and only one memory transaction is outstanding at a time. Two counters record the hits and the misses, so the hit ratio of an access pattern can be measured.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, `cpu_done` is 0, `mem_req` is 0, both counters are 0 and every line is invalid, so the first access to any address (address 0 included) misses.
- R2: The line index is `cpu_addr[INDEX_W-1:0]` and the tag is the upper `ADDR_W-INDEX_W` bits. Addresses with different indices occupy separate lines at the same time. Addresses whose difference is a multiple of the line count (1024 by default) share one line.
- R3: A read hit returns the stored word with no memory transaction. `cpu_done` rises in the second cycle after the acceptance edge and lasts one cycle.
- R4: A read miss issues exactly one memory read (`mem_we`=0) at the requested word address. It returns `mem_rdata` on `cpu_rdata` and installs the line, so an immediate re-read hits.
- R5: A write hit updates the cached word and issues one memory write (`mem_we`=1) carrying the same address and data.
- R6: A write miss issues one memory write and installs the new tag and written data, so a following read of that address hits and returns the written word.
- R7: Reads that alternate between two addresses mapping to the same line (for example 1024 and 2048) miss on every access.
- R8: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. `cpu_ready` is low from acceptance until completion. `cpu_done` and the return of `cpu_ready` coincide, in the cycle after the acknowledge.
- R9: Processor request inputs that change while `cpu_ready` is low are ignored. They cause no memory transaction, and they install nothing in the cache.
- R10: `hit_count` rises by one on each hit and `miss_count` by one on each miss. This counts reads and writes alike, and neither counter changes on any other event.
- R11: The controller completes correctly for any memory latency, including an acknowledge in the first cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, accepted while `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller idle and accepting a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` after a read |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write strobe qualifier |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| hit_count | output | CNT_W | Number of hits since reset |
| miss_count | output | CNT_W | Number of misses since reset |

## Verification
A stale or wrongly set valid bit, or a corrupted tag, shows up on the next access to that line. If it fakes a hit, a read completes two cycles after acceptance with no memory read, and it returns the wrong word or moves the wrong counter. If it fakes a miss, a memory read appears that should not have. Either way the fault shows at the first `cpu_done` of that access. A controller state that forgets a pending transaction appears as a changed memory request before the acknowledge, or as a missing or extra completion pulse. The bench's reference tag model predicts every hit and every memory transaction, so the fault is caught within the access that exposes it.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_LOOKUP    = 2'd1,
    ST_MEM_READ  = 2'd2,
    ST_MEM_WRITE = 2'd3
  } dmc_state_e;

endpackage

// File: rtl/dmc_array.sv
// Line storage: tag and data share one RAM word; valid bits live in flops
// so that reset can clear them in a single cycle.
module dmc_array #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [INDEX_W-1:0] rd_idx,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int LINES  = 1 << INDEX_W;
  localparam int WORD_W = TAG_W + DATA_W;

  logic [WORD_W-1:0] store [LINES];
  logic [WORD_W-1:0] rd_word;
  logic [LINES-1:0]  valid_q;

  // Single-port style RAM: the controller never reads and writes in one cycle.
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= {wr_tag, wr_data};
    if (rd_en) rd_word <= store[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= valid_q[rd_idx];
    end
  end

  assign rd_tag  = rd_word[WORD_W-1:DATA_W];
  assign rd_data = rd_word[DATA_W-1:0];
endmodule

// File: rtl/dmc_counter.sv
module dmc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  output logic                      cpu_ready,
  output logic                      cpu_done,
  output logic [DATA_W-1:0]         cpu_rdata,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic                      mem_ack,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      arr_rd_en,
  output logic [INDEX_W-1:0]        arr_rd_idx,
  output logic                      arr_wr_en,
  output logic [INDEX_W-1:0]        arr_wr_idx,
  output logic [ADDR_W-INDEX_W-1:0] arr_wr_tag,
  output logic [DATA_W-1:0]         arr_wr_data,
  input  logic                      arr_rd_valid,
  input  logic [ADDR_W-INDEX_W-1:0] arr_rd_tag,
  input  logic [DATA_W-1:0]         arr_rd_data,
  output logic                      hit_pulse,
  output logic                      miss_pulse
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  dmc_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic              accept;
  logic              tag_match;
  logic [TAG_W-1:0]  tag_q;

  assign accept     = cpu_req && cpu_ready;
  assign tag_q      = addr_q[ADDR_W-1:INDEX_W];
  assign arr_rd_en  = accept;
  assign arr_rd_idx = cpu_addr[INDEX_W-1:0];

  // The one comparator of the cache.
  assign tag_match  = arr_rd_valid && (arr_rd_tag == tag_q);
  assign hit_pulse  = (state == ST_LOOKUP) && tag_match;
  assign miss_pulse = (state == ST_LOOKUP) && !tag_match;

  // Writes allocate during lookup; read misses fill on the acknowledge.
  always_comb begin
    arr_wr_en   = 1'b0;
    arr_wr_data = wdata_q;
    if (state == ST_LOOKUP && we_q) begin
      arr_wr_en = 1'b1;
    end else if (state == ST_MEM_READ && mem_ack) begin
      arr_wr_en   = 1'b1;
      arr_wr_data = mem_rdata;
    end
  end
  assign arr_wr_idx = addr_q[INDEX_W-1:0];
  assign arr_wr_tag = tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpu_ready <= 1'b1;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
    end else begin
      cpu_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            addr_q    <= cpu_addr;
            wdata_q   <= cpu_wdata;
            we_q      <= cpu_we;
            cpu_ready <= 1'b0;
            state     <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (we_q) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= addr_q;
            mem_wdata <= wdata_q;
            state     <= ST_MEM_WRITE;
          end else if (tag_match) begin
            cpu_rdata <= arr_rd_data;
            cpu_done  <= 1'b1;
            cpu_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= addr_q;
            state    <= ST_MEM_READ;
          end
        end
        ST_MEM_READ: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_rdata <= mem_rdata;
            cpu_done  <= 1'b1;
            cpu_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_MEM_WRITE: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_done  <= 1'b1;
            cpu_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 10,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic               arr_rd_en, arr_wr_en, arr_rd_valid;
  logic [INDEX_W-1:0] arr_rd_idx, arr_wr_idx;
  logic [TAG_W-1:0]   arr_wr_tag, arr_rd_tag;
  logic [DATA_W-1:0]  arr_wr_data, arr_rd_data;
  logic               hit_pulse, miss_pulse;

  dmc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .arr_rd_en(arr_rd_en), .arr_rd_idx(arr_rd_idx),
    .arr_wr_en(arr_wr_en), .arr_wr_idx(arr_wr_idx),
    .arr_wr_tag(arr_wr_tag), .arr_wr_data(arr_wr_data),
    .arr_rd_valid(arr_rd_valid), .arr_rd_tag(arr_rd_tag), .arr_rd_data(arr_rd_data),
    .hit_pulse(hit_pulse), .miss_pulse(miss_pulse)
  );

  dmc_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst(rst),
    .rd_en(arr_rd_en), .rd_idx(arr_rd_idx),
    .wr_en(arr_wr_en), .wr_idx(arr_wr_idx), .wr_tag(arr_wr_tag), .wr_data(arr_wr_data),
    .rd_valid(arr_rd_valid), .rd_tag(arr_rd_tag), .rd_data(arr_rd_data)
  );

  dmc_counter #(.CNT_W(CNT_W)) u_hits (
    .clk(clk), .rst(rst), .inc(hit_pulse), .count(hit_count)
  );

  dmc_counter #(.CNT_W(CNT_W)) u_misses (
    .clk(clk), .rst(rst), .inc(miss_pulse), .count(miss_count)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  a_r8_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r8_stall_while_mem: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  a_r8_ack_completes: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (!mem_req && cpu_done && cpu_ready));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  a_r10_hit_step: assert property (@(posedge clk) disable iff (rst)
    (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + 1'b1));

  a_r10_miss_step: assert property (@(posedge clk) disable iff (rst)
    (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + 1'b1));

  a_r10_one_event: assert property (@(posedge clk) disable iff (rst)
    $stable(hit_count) || $stable(miss_count));
endmodule

bind dm_wt_cache dmc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/dm_wt_cache_bench.sv
module dm_wt_cache_bench;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int INDEX_W = 10;
  localparam int CNT_W   = 16;
  localparam int LINES   = 1 << INDEX_W;
  localparam int TAG_W   = ADDR_W - INDEX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_ready, cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [CNT_W-1:0]  hit_count, miss_count;

  always #5 clk = ~clk;

  dm_wt_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W), .CNT_W(CNT_W)) u_dm_wt_cache (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DATA_W-1:0] wrmap [int];
  int mem_lat = 2;
  int wait_cnt = 0;
  int mrd_cnt = 0, mwr_cnt = 0;
  logic [ADDR_W-1:0] last_ra = '0, last_wa = '0;
  logic [DATA_W-1:0] last_wd = '0;

  function automatic logic [DATA_W-1:0] memval(input int a);
    if (wrmap.exists(a)) return wrmap[a];
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (!rst && mem_req) begin
      if (wait_cnt >= mem_lat) begin
        wait_cnt = 0;
        mem_ack  = 1'b1;
        if (mem_we) begin
          wrmap[int'(mem_addr)] = mem_wdata;
          mwr_cnt++;
          last_wa = mem_addr;
          last_wd = mem_wdata;
        end else begin
          mem_rdata = memval(int'(mem_addr));
          mrd_cnt++;
          last_ra = mem_addr;
        end
      end else wait_cnt++;
    end
  end

  // ---------------- reference model and scoreboard ----------------
  typedef struct {
    bit                we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    int                hits, misses, mrd, mwr, issue;
    bit                lat_chk;
    string             req;
  } item_t;
  item_t q[$];

  bit               ref_v [LINES];
  logic [TAG_W-1:0] ref_t [LINES];
  int exp_h = 0, exp_m = 0, exp_rd = 0, exp_wr = 0;

  task automatic do_op(input bit we, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input string req, input bit noisy);
    item_t it;
    int idx;
    bit hit;
    while (!cpu_ready) @(negedge clk);
    idx = int'(a[INDEX_W-1:0]);
    hit = ref_v[idx] && (ref_t[idx] == a[ADDR_W-1:INDEX_W]);
    if (hit) exp_h++; else exp_m++;
    if (we) exp_wr++;
    else if (!hit) exp_rd++;
    if (we || !hit) begin
      ref_v[idx] = 1'b1;
      ref_t[idx] = a[ADDR_W-1:INDEX_W];
    end
    it.we = we; it.addr = a; it.data = we ? d : memval(int'(a));
    it.hits = exp_h; it.misses = exp_m; it.mrd = exp_rd; it.mwr = exp_wr;
    it.issue = cyc; it.lat_chk = !we && hit; it.req = req;
    q.push_back(it);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    if (noisy) begin
      // R9: scribble on the request inputs while stalled
      for (int g = 0; !cpu_ready; g++) begin
        chk(cpu_ready == 1'b0, "R8", "ready during stall", cpu_ready, 0);
        cpu_req = 1'b1; cpu_we = 1'b1;
        cpu_addr = ADDR_W'(16'h0300 + g); cpu_wdata = 32'hDEAD0000 + g;
        @(negedge clk);
      end
    end
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  initial forever begin
    @(negedge clk);
    if (!rst && cpu_done) begin
      if (q.size() == 0) chk(1'b0, "R8", "unexpected done", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        if (!it.we) chk(cpu_rdata == it.data, it.req, "rdata", cpu_rdata, it.data);
        chk(hit_count == CNT_W'(it.hits), "R10", "hit_count", hit_count, it.hits);
        chk(miss_count == CNT_W'(it.misses), "R10", "miss_count", miss_count, it.misses);
        chk(mrd_cnt == it.mrd, it.req, "memory reads", mrd_cnt, it.mrd);
        chk(mwr_cnt == it.mwr, it.req, "memory writes", mwr_cnt, it.mwr);
        if (it.lat_chk) chk(cyc - it.issue == 2, "R3", "hit latency", cyc - it.issue, 2);
        if (it.we) begin
          chk(last_wa == it.addr, it.req, "write-through addr", last_wa, it.addr);
          chk(last_wd == it.data, it.req, "write-through data", last_wd, it.data);
        end else if (!it.lat_chk) begin
          chk(last_ra == it.addr, "R4", "fill addr", last_ra, it.addr);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < LINES; i++) begin ref_v[i] = 1'b0; ref_t[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R1", "ready after reset", cpu_ready, 1);
    chk(cpu_done == 1'b0, "R1", "done after reset", cpu_done, 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
    chk(hit_count == 0 && miss_count == 0, "R1", "counters after reset",
        {hit_count, miss_count}, 0);

    mem_lat = 3;
    do_op(0, 16'd0, '0, "R1", 0);              // invalid line: miss
    do_op(0, 16'd0, '0, "R3", 0);              // read hit
    do_op(1, 16'd0, 32'hCAFE0001, "R5", 0);    // write hit
    do_op(0, 16'd0, '0, "R5", 0);              // hit returns new word
    do_op(1, 16'd5, 32'hBEEF0005, "R6", 0);    // write miss allocates
    do_op(0, 16'd5, '0, "R6", 0);              // hit with written word
    do_op(0, 16'd1029, '0, "R2", 0);           // same line as 5: miss
    do_op(0, 16'd5, '0, "R2", 0);              // evicted: miss
    for (int i = 0; i < 6; i++)                // R7 thrashing
      do_op(0, (i % 2) ? 16'd2048 : 16'd1024, '0, "R7", 0);
    do_op(0, 16'd7, '0, "R2", 0);
    do_op(0, 16'd8, '0, "R2", 0);
    do_op(0, 16'd7, '0, "R2", 0);              // separate lines coexist
    mem_lat = 0;
    do_op(0, 16'd9, '0, "R11", 0);
    do_op(1, 16'd9, 32'h11110009, "R11", 0);
    mem_lat = 9;
    do_op(0, 16'd10, '0, "R11", 0);
    do_op(0, 16'd10, '0, "R11", 0);
    mem_lat = 6;
    do_op(0, 16'd12, '0, "R9", 1);             // noisy stall
    do_op(0, 16'h0301, '0, "R9", 0);           // scribbled address not installed
    do_op(0, 16'd12, '0, "R9", 0);
    mem_lat = 1;
    do_op(0, 16'hFFFF, '0, "R4", 0);           // top index, top tag
    do_op(0, 16'hFFFF, '0, "R3", 0);

    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule